// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter

This block connects an 8-bit processor whose low address byte and data share the same pins to a system that expects a separate 16-bit address bus and a separate data bus. The processor provides three kinds of signal: the upper address byte on its own pins, the shared low byte, and an address strobe. For bus control it also provides active-low read and write strobes and a line that selects IO space or memory space.

On every clock edge where the address strobe is high, the block records the full 16-bit address. It keeps that address on the system side until the next strobe, even while the shared pins carry data. A small cycle controller follows the read and write strobes. One clock later it asserts exactly one of four active-low system strobes: memory read, memory write, IO read or IO write. It also turns the data path in the direction that strobe needs. Each side of the data path has its own output enable, and the pad ring combines it with the output value to form the tri-state pins.

The controller has four states:
- **IDLE**: the state after reset, before any address has been captured.
- **ADDR**: an address is held and no strobe is active.
- **READ**: a read is in progress.
- **WRITE**: a write is in progress.

Its transitions are:
- **capture**: from any state to ADDR when the address strobe is high.
- **rd_start**: ADDR to READ when the read strobe is low.
- **wr_start**: ADDR to WRITE when the write strobe is low and the read strobe is high.
- **rd_end**: READ to ADDR when the read strobe returns high.
- **wr_end**: WRITE to ADDR when the write strobe returns high.

Top module: `busdx_top`

## Requirements
- R1: While reset is low, and on the first clock after it, all four system strobes are high (inactive), both output enables are low and `sys_addr` is 0.
- R2: On a rising clock edge with `ale` high, `sys_addr` takes `{cpu_addr_hi, cpu_ad_in}`, with the high byte in bits 15:8. The new value is visible after that edge.
- R3: On an edge with `ale` low, `sys_addr` keeps its value, whatever `cpu_addr_hi` and `cpu_ad_in` do.
- R4: A read started from ADDR asserts `io_rd_n` low after the next edge if `io_sel` was 1 at that edge, and `mem_rd_n` low if `io_sel` was 0. The strobe stays low until an edge sees `rd_n` high, and it goes high after that edge.
- R5: The same rule as R4 applies to writes, using `wr_n` and the outputs `io_wr_n` and `mem_wr_n`.
- R6: At no time is more than one of the four system strobes low.
- R7: During a read, `cpu_ad_oe` is 1, `cpu_ad_out` equals `sys_data_in`, and `sys_data_oe` is 0.
- R8: During a write, `sys_data_oe` is 1, `sys_data_out` equals `cpu_ad_in`, and `cpu_ad_oe` is 0.
- R9: The two output enables are never high together. When no system strobe is low, both enables are low.
- R10: If `rd_n` and `wr_n` are both low at the start edge, a read is performed.
- R11: The space chosen at the start edge holds for the whole access. A change of `io_sel` during the access has no effect.
- R12: In IDLE, with no address captured since reset, low read or write strobes are ignored and all system strobes stay high.
- R13: An edge with `ale` high during an access ends that access. After that edge all system strobes are high and the new address is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_hi | input | 8 | Upper address byte from the processor |
| cpu_ad_in | input | 8 | Shared low-address/data pins, input value |
| cpu_ad_out | output | 8 | Read data toward the processor |
| cpu_ad_oe | output | 1 | Drive enable for the processor-side pins |
| ale | input | 1 | Address strobe; high marks the address phase |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| io_sel | input | 1 | 1 selects IO space, 0 selects memory |
| sys_addr | output | 16 | Held 16-bit address |
| sys_data_in | input | 8 | Data returned by the system |
| sys_data_out | output | 8 | Write data toward the system |
| sys_data_oe | output | 1 | Drive enable for the system data bus |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | IO read strobe, active low |
| io_wr_n | output | 1 | IO write strobe, active low |

## Verification
The assertions assume that all inputs change only away from the rising clock edge. They also assume that the address strobe and the read/write strobes are stable for whole clock periods. The bench drives every input just after a falling edge and holds it for at least one full period. The checks on strobe origin compare against the inputs at the previous edge, so they hold only if the space select does not change in the same period as the strobe falls. The bench keeps `io_sel` steady around every strobe start, and changes it only in the middle of an access when it tests R11.

// File: rtl/busdx_pkg.sv
package busdx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ADDR  = 2'd1,
        S_READ  = 2'd2,
        S_WRITE = 2'd3
    } cyc_state_t;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1,
                                        io_rd_n: 1'b1, io_wr_n: 1'b1};
endpackage

// File: rtl/busdx_addr_hold.sv
module busdx_addr_hold #(
    parameter int HI_W = 8,
    parameter int LO_W = 8,
    localparam int ADDR_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic [LO_W-1:0]   ad_lo,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ale) begin
            addr_q <= {addr_hi, ad_lo};
        end
    end

    // R2
    ale_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (addr_q == {$past(addr_hi), $past(ad_lo)}));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(addr_q));
endmodule

// File: rtl/busdx_cycle_fsm.sv
module busdx_cycle_fsm
    import busdx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ale,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       io_sel,
    output cyc_state_t state,
    output logic       io_q
);
    cyc_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (ale) state_nx = S_ADDR;
            end
            S_ADDR: begin
                if (ale)        state_nx = S_ADDR;
                else if (!rd_n) state_nx = S_READ;
                else if (!wr_n) state_nx = S_WRITE;
            end
            S_READ: begin
                if (ale || rd_n) state_nx = S_ADDR;
            end
            S_WRITE: begin
                if (ale || wr_n) state_nx = S_ADDR;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_q <= 1'b0;
        end else if (state == S_ADDR && (state_nx == S_READ || state_nx == S_WRITE)) begin
            io_q <= io_sel;
        end
    end

    // R12
    idle_ignores_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> (state == S_IDLE || state == S_ADDR));

    // R11
    space_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ || state == S_WRITE) |=> $stable(io_q));

    // R10
    read_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && !ale && !rd_n && !wr_n) |=> (state == S_READ));
endmodule

// File: rtl/busdx_strobe_dec.sv
module busdx_strobe_dec
    import busdx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cyc_state_t state,
    input  logic       io_q,
    output strobe_t    strb
);
    always_comb begin
        strb = STROBE_IDLE;
        unique case (state)
            S_READ: begin
                if (io_q) strb.io_rd_n  = 1'b0;
                else      strb.mem_rd_n = 1'b0;
            end
            S_WRITE: begin
                if (io_q) strb.io_wr_n  = 1'b0;
                else      strb.mem_wr_n = 1'b0;
            end
            default: strb = STROBE_IDLE;
        endcase
    end

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{strb.mem_rd_n, strb.mem_wr_n, strb.io_rd_n, strb.io_wr_n}));
endmodule

// File: rtl/busdx_data_steer.sv
module busdx_data_steer
    import busdx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cyc_state_t    state,
    input  logic [DW-1:0] cpu_ad_in,
    input  logic [DW-1:0] sys_data_in,
    output logic [DW-1:0] cpu_ad_out,
    output logic          cpu_ad_oe,
    output logic [DW-1:0] sys_data_out,
    output logic          sys_data_oe
);
    always_comb begin
        cpu_ad_oe    = 1'b0;
        sys_data_oe  = 1'b0;
        cpu_ad_out   = '0;
        sys_data_out = '0;
        unique case (state)
            S_READ: begin
                cpu_ad_oe  = 1'b1;
                cpu_ad_out = sys_data_in;
            end
            S_WRITE: begin
                sys_data_oe  = 1'b1;
                sys_data_out = cpu_ad_in;
            end
            default: begin
                cpu_ad_oe   = 1'b0;
                sys_data_oe = 1'b0;
            end
        endcase
    end

    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ad_oe && sys_data_oe));
endmodule

// File: rtl/busdx_top.sv
module busdx_top
    import busdx_pkg::*;
#(
    parameter int HI_W = 8,
    parameter int LO_W = 8,
    localparam int ADDR_W = HI_W + LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HI_W-1:0]   cpu_addr_hi,
    input  logic [LO_W-1:0]   cpu_ad_in,
    output logic [LO_W-1:0]   cpu_ad_out,
    output logic              cpu_ad_oe,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              io_sel,
    output logic [ADDR_W-1:0] sys_addr,
    input  logic [LO_W-1:0]   sys_data_in,
    output logic [LO_W-1:0]   sys_data_out,
    output logic              sys_data_oe,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n
);
    cyc_state_t state;
    logic       io_q;
    strobe_t    strb;

    busdx_addr_hold #(.HI_W(HI_W), .LO_W(LO_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .ale(ale),
        .addr_hi(cpu_addr_hi), .ad_lo(cpu_ad_in), .addr_q(sys_addr)
    );

    busdx_cycle_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .io_sel(io_sel), .state(state), .io_q(io_q)
    );

    busdx_strobe_dec u_dec (
        .clk(clk), .rst_n(rst_n), .state(state), .io_q(io_q), .strb(strb)
    );

    busdx_data_steer #(.DW(LO_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .state(state),
        .cpu_ad_in(cpu_ad_in), .sys_data_in(sys_data_in),
        .cpu_ad_out(cpu_ad_out), .cpu_ad_oe(cpu_ad_oe),
        .sys_data_out(sys_data_out), .sys_data_oe(sys_data_oe)
    );

    assign mem_rd_n = strb.mem_rd_n;
    assign mem_wr_n = strb.mem_wr_n;
    assign io_rd_n  = strb.io_rd_n;
    assign io_wr_n  = strb.io_wr_n;

    // R4
    mem_rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> ($past(!rd_n) && $past(!io_sel)));

    // R4
    io_rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_rd_n) |-> ($past(!rd_n) && $past(io_sel)));

    // R5
    mem_wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> ($past(!wr_n) && $past(!io_sel)));

    // R5
    io_wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(io_wr_n) |-> ($past(!wr_n) && $past(io_sel)));

    // R13
    ale_ends_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n));

    // R7
    read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !io_rd_n) |-> (cpu_ad_oe && !sys_data_oe && cpu_ad_out == sys_data_in));

    // R8
    write_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_n || !io_wr_n) |-> (sys_data_oe && !cpu_ad_oe && sys_data_out == cpu_ad_in));

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n) |-> (!cpu_ad_oe && !sys_data_oe));
endmodule

// File: tb/tb_busdx_top.sv
module tb_busdx_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cpu_addr_hi, cpu_ad_in, cpu_ad_out, sys_data_in, sys_data_out;
    logic        cpu_ad_oe, sys_data_oe, ale, rd_n, wr_n, io_sel;
    logic [15:0] sys_addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busdx_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi), .cpu_ad_in(cpu_ad_in),
        .cpu_ad_out(cpu_ad_out), .cpu_ad_oe(cpu_ad_oe), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .io_sel(io_sel), .sys_addr(sys_addr), .sys_data_in(sys_data_in),
        .sys_data_out(sys_data_out), .sys_data_oe(sys_data_oe), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
    );

    // vector: {hi[25:18], lo[17:10], io[9], write[8], data[7:0]}
    localparam int NVEC = 6;
    localparam logic [25:0] VEC [NVEC] = '{
        {8'h12, 8'h34, 1'b0, 1'b0, 8'hA5},
        {8'hFF, 8'h00, 1'b1, 1'b0, 8'h3C},
        {8'h00, 8'hFF, 1'b0, 1'b1, 8'h5A},
        {8'h80, 8'h01, 1'b1, 1'b1, 8'hC3},
        {8'hAB, 8'hCD, 1'b0, 1'b1, 8'h00},
        {8'h7E, 8'h81, 1'b1, 1'b0, 8'hFF}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes();
        return {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
    endfunction

    task automatic load_addr(input logic [7:0] hi, input logic [7:0] lo);
        cpu_addr_hi = hi; cpu_ad_in = lo; ale = 1'b1;
        step();
        ale = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ale = 1'b0; rd_n = 1'b1; wr_n = 1'b1; io_sel = 1'b0;
        cpu_addr_hi = 8'h55; cpu_ad_in = 8'hAA; sys_data_in = 8'h99;
        step(); step();
        // R1 reset state
        chk(strobes() == 4'hF && !cpu_ad_oe && !sys_data_oe && sys_addr == 16'h0,
            "R1 reset", {strobes(), cpu_ad_oe, sys_data_oe, sys_addr}, {4'hF, 2'b00, 16'h0});
        rst_n = 1'b1;
        step();
        chk(strobes() == 4'hF && sys_addr == 16'h0, "R1 after reset",
            {strobes(), sys_addr}, {4'hF, 16'h0});

        // R12 strobes before any address are ignored
        rd_n = 1'b0; step(); step();
        chk(strobes() == 4'hF && !cpu_ad_oe, "R12 idle read", strobes(), 4'hF);
        rd_n = 1'b1; wr_n = 1'b0; step();
        chk(strobes() == 4'hF && !sys_data_oe, "R12 idle write", strobes(), 4'hF);
        wr_n = 1'b1; step();

        // table walk: R2 R4 R5 R7 R8 R6 R9
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] hi, lo, dat;
            logic io, wr;
            logic [3:0] exp_s;
            hi = VEC[i][25:18]; lo = VEC[i][17:10]; io = VEC[i][9]; wr = VEC[i][8]; dat = VEC[i][7:0];
            io_sel = io;
            load_addr(hi, lo);
            chk(sys_addr == {hi, lo}, "R2 capture", sys_addr, {hi, lo});
            if (wr) begin
                cpu_ad_in = dat; sys_data_in = ~dat; wr_n = 1'b0;
            end else begin
                cpu_ad_in = ~dat; sys_data_in = dat; rd_n = 1'b0;
            end
            step();
            exp_s = 4'hF;
            if (!wr && !io) exp_s[3] = 1'b0;
            if ( wr && !io) exp_s[2] = 1'b0;
            if (!wr &&  io) exp_s[1] = 1'b0;
            if ( wr &&  io) exp_s[0] = 1'b0;
            chk(strobes() == exp_s, wr ? "R5 write strobe" : "R4 read strobe", strobes(), exp_s);
            if (wr)
                chk(sys_data_oe && !cpu_ad_oe && sys_data_out == dat, "R8 write path",
                    {sys_data_oe, cpu_ad_oe, sys_data_out}, {2'b10, dat});
            else
                chk(cpu_ad_oe && !sys_data_oe && cpu_ad_out == dat, "R7 read path",
                    {cpu_ad_oe, sys_data_oe, cpu_ad_out}, {2'b10, dat});
            chk(sys_addr == {hi, lo}, "R3 held during data", sys_addr, {hi, lo});
            step();
            chk(strobes() == exp_s, "R4 strobe held", strobes(), exp_s);
            rd_n = 1'b1; wr_n = 1'b1;
            step();
            chk(strobes() == 4'hF && !cpu_ad_oe && !sys_data_oe, "R9 released",
                {strobes(), cpu_ad_oe, sys_data_oe}, {4'hF, 2'b00});
        end

        // R3 address stable while shared pins and high byte toggle
        load_addr(8'h3A, 8'hC5);
        for (int k = 0; k < 4; k++) begin
            cpu_ad_in = 8'(k * 37); cpu_addr_hi = 8'(k * 91);
            step();
        end
        chk(sys_addr == 16'h3AC5, "R3 hold", sys_addr, 16'h3AC5);

        // R10 both strobes low -> read
        io_sel = 1'b0; sys_data_in = 8'h6D;
        rd_n = 1'b0; wr_n = 1'b0;
        step();
        chk(strobes() == 4'b0111 && cpu_ad_oe && !sys_data_oe, "R10 read wins",
            {strobes(), cpu_ad_oe, sys_data_oe}, {4'b0111, 2'b10});
        rd_n = 1'b1; wr_n = 1'b1; step();

        // R11 io_sel change mid-access ignored
        io_sel = 1'b1; wr_n = 1'b0; cpu_ad_in = 8'h42;
        step();
        chk(strobes() == 4'b1110, "R11 io write start", strobes(), 4'b1110);
        io_sel = 1'b0; step(); step();
        chk(strobes() == 4'b1110, "R11 io write kept", strobes(), 4'b1110);
        wr_n = 1'b1; step();

        // R13 address strobe during a read ends it
        io_sel = 1'b0; rd_n = 1'b0; step();
        chk(strobes() == 4'b0111, "R13 read active", strobes(), 4'b0111);
        cpu_addr_hi = 8'hE1; cpu_ad_in = 8'h1E; ale = 1'b1;
        step();
        ale = 1'b0;
        chk(strobes() == 4'hF && sys_addr == 16'hE11E, "R13 ale ends access",
            {strobes(), sys_addr}, {4'hF, 16'hE11E});
        rd_n = 1'b1; step();
        chk(strobes() == 4'hF, "R6 all idle", strobes(), 4'hF);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule